// File: doc/BRIEF.md
# Frame-Aligned Serial Word Receiver

This block sits at the receiving end of a fast one-way serial link that streams 32-bit words, most significant bit first, together with a bit clock and a frame strobe. It samples all three link signals in a faster system clock, finds the rising edges of the bit clock, and uses the frame strobe to find where each word begins. It then delivers each finished word as a parallel value with a one-cycle valid pulse. The link can run at roughly 5 MHz or 10 MHz. Its bit clock may run all the time, or stop low between bursts.

The strobe is one bit period wide. It is asserted during the bit period just before the first bit of a field. A 2-bit setting selects how often strobes are expected: once per burst, every 8 bits, every 16 bits or every 32 bits. A second setting selects whether the strobe is active high or active low. A strobe that falls where the selected spacing does not allow raises an alignment-error pulse, and word assembly starts again after that strobe. The block keeps a count of words received in the current burst. A burst ends when the bit clock stays quiet for a programmable number of system clocks. Any partial word is then dropped.

Top module: `fsync_rx`

## Requirements
- R1: Each word is assembled MSB first from 32 consecutive bits. It appears on `word_o` with `word_valid_o` high for exactly one system clock, and `word_o` holds its value between pulses. `word_valid_o` rises 3 system clocks after the bit-clock rising edge that carries bit 0 arrives at the pin.
- R2: Data is taken on the bit-clock rising edge. The first bit of a word is the one sampled on the edge after the edge at which the strobe is seen active. Bits that arrive before the first strobe of a burst are ignored.
- R3: With `cfg_gran` = 2'b11, a strobe precedes every word. Consecutive strobed words are each delivered correctly.
- R4: With `cfg_gran` = 2'b00, only the first word of a burst is preceded by a strobe. Later word boundaries follow every 32 bits by counting.
- R5: With `cfg_gran` = 2'b01 (strobe every 8 bits) or 2'b10 (every 16 bits), strobes that land on those bit positions inside a word are accepted, and the words are delivered unchanged.
- R6: A strobe that lands on a position the spacing does not allow (bit count not a multiple of 8, 16 or 32 for modes 01, 10, and 11 or 00) gives a one-cycle `align_err_o` pulse. It drops the partial word, and assembly restarts with the next bit as MSB.
- R7: With `cfg_pol` = 0 the strobe is active high. With `cfg_pol` = 1 it is active low.
- R8: `word_cnt_o` is 0 after reset. It goes up by one with each delivered word, and is cleared by the first strobe of a new burst, so the first word of a burst reports 1.
- R9: When no bit-clock rising edge is seen for `IDLE_LIMIT` system clocks, `burst_active_o` falls and any partial word is discarded.
- R10: In modes 01, 10 and 11, once a word is complete, further bit-clock edges without a strobe are ignored. A continuously running bit clock between bursts therefore produces no words.
- R11: Both about 10 MHz and about 5 MHz bit rates are received correctly with the default 250 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| sdata_in | input | 1 | Serial data, MSB first |
| sfr_in | input | 1 | Frame strobe |
| cfg_gran | input | 2 | Strobe spacing: 00 burst, 01 8 bits, 10 16 bits, 11 32 bits |
| cfg_pol | input | 1 | Strobe polarity: 0 active high, 1 active low |
| word_o | output | 32 | Last assembled word |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` is new |
| word_cnt_o | output | CNT_W | Words received in the current burst |
| align_err_o | output | 1 | One-cycle pulse on a misplaced strobe |
| burst_active_o | output | 1 | High from first strobe until the bit-clock timeout |

## Verification
Every result depends on the bit-clock edge that sets it off. The edge passes two synchronizer flops and one output register, so both `word_valid_o` and `align_err_o` are due on the third system clock after the bench raises the bit clock. The bench raises the bit clock on a falling system-clock edge and restarts a cycle counter at that moment. The monitor reads outputs on falling edges and requires the counter to show exactly 3 when a word pulse appears, then compares the word and count against the scoreboard entry the driver queued before the final bit. The burst-end flag is checked only after a quiet gap well beyond `IDLE_LIMIT`.

// File: rtl/fsync_rx.sv
module fsync_rx #(
  parameter int WORD_W     = 32,
  parameter int CNT_W      = 8,
  parameter int IDLE_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              sfr_in,
  input  logic [1:0]        cfg_gran,
  input  logic              cfg_pol,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic [CNT_W-1:0]  word_cnt_o,
  output logic              align_err_o,
  output logic              burst_active_o
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(IDLE_LIMIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_SAT = IDLE_W'(IDLE_LIMIT);

  logic [2:0]        sclk_q;
  logic [1:0]        sdat_q, sfr_q;
  logic              in_burst, active;
  logic [BIT_W-1:0]  bitcnt;
  logic [WORD_W-1:0] shreg;
  logic [IDLE_W-1:0] idle_cnt;

  wire              rise   = sclk_q[1] & ~sclk_q[2];
  wire              fr     = sfr_q[1] ^ cfg_pol;
  wire [BIT_W-1:0]  nb     = bitcnt + 1'b1;
  wire              done   = active & (bitcnt == LAST_BIT);
  wire [BIT_W-1:0]  mask   = (cfg_gran == 2'b01) ? BIT_W'(7) :
                             (cfg_gran == 2'b10) ? BIT_W'(15) : LAST_BIT;
  wire              misfit = active & ((nb & mask) != '0);
  wire              expire = ~rise & (idle_cnt == IDLE_END);
  wire [WORD_W-1:0] next_w = {shreg[WORD_W-2:0], sdat_q[1]};

  assign burst_active_o = in_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      sfr_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_in};
      sdat_q <= {sdat_q[0], sdata_in};
      sfr_q  <= {sfr_q[0], sfr_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= IDLE_SAT;
    else if (rise)              idle_cnt <= '0;
    else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst     <= 1'b0;
      active       <= 1'b0;
      bitcnt       <= '0;
      shreg        <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      word_cnt_o   <= '0;
      align_err_o  <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      align_err_o  <= 1'b0;
      if (expire) begin
        in_burst <= 1'b0;
        active   <= 1'b0;
        bitcnt   <= '0;
      end else if (rise) begin
        if (active) shreg <= next_w;
        if (done) begin
          word_o       <= next_w;
          word_valid_o <= 1'b1;
          word_cnt_o   <= word_cnt_o + 1'b1;
        end
        if (fr) begin
          in_burst    <= 1'b1;
          active      <= 1'b1;
          bitcnt      <= (active && !misfit) ? nb : '0;
          align_err_o <= misfit;
          if (!in_burst) word_cnt_o <= '0;
        end else if (active) begin
          bitcnt <= nb;
          if (done && cfg_gran != 2'b00) active <= 1'b0;
        end
      end
    end
  end
endmodule

module fsync_rx_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic [CNT_W-1:0]  word_cnt_o,
  input logic              align_err_o,
  input logic              burst_active_o
);
  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);
  assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> $stable(word_o));
  assert_err_not_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> !word_valid_o);
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> word_cnt_o == $past(word_cnt_o) + 1'b1);
  assert_word_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> burst_active_o);
endmodule

bind fsync_rx fsync_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .word_valid_o(word_valid_o),
  .word_cnt_o(word_cnt_o), .align_err_o(align_err_o),
  .burst_active_o(burst_active_o)
);

// File: tb/fsync_rx_tb.sv
module fsync_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sfr = 1'b0;
  logic [1:0] gran = 2'b11;
  logic pol = 1'b0;
  logic [31:0] word;
  logic valid, aerr, bact;
  logic [7:0] wcnt;

  typedef struct packed { logic [31:0] w; logic [7:0] c; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, exp_cnt = 0, since_rise = 100, err_seen = 0;
  int half = 12, seed = 0;

  always #2 clk = ~clk;

  fsync_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(sdata), .sfr_in(sfr),
    .cfg_gran(gran), .cfg_pol(pol), .word_o(word), .word_valid_o(valid),
    .word_cnt_o(wcnt), .align_err_o(aerr), .burst_active_o(bact)
  );

  always @(posedge clk) since_rise <= since_rise + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && aerr) err_seen++;
    if (rst_n && valid) begin
      if (q.size() == 0) check(1'b0, "R1/R10 unexpected word", word, 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(word == e.w, "R1 word value", word, e.w);
        check(wcnt == e.c, "R8 word count", 32'(wcnt), 32'(e.c));
        check(since_rise == 3, "R1 latency", 32'(since_rise), 32'd3);
      end
    end
  end

  function automatic logic [31:0] gen(input int i);
    return 32'(i * 32'h9E3779B9) ^ 32'h5A0FC3E1;
  endfunction

  task automatic drive_bit(input logic d, input logic f);
    sdata = d;
    sfr = f ^ pol;
    repeat (half) @(negedge clk);
    sclk = 1'b1;
    since_rise = 0;
    repeat (half) @(negedge clk);
    sclk = 1'b0;
  endtask

  function automatic bit boundary(input int k, input logic [1:0] g);
    case (g)
      2'b01:   return (k % 8) == 0;
      2'b10:   return (k % 16) == 0;
      2'b11:   return (k % 32) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send_word(input logic [31:0] w, input bit more);
    for (int k = 1; k <= 32; k++) begin
      if (k == 32) begin
        exp_cnt++;
        q.push_back('{w: w, c: 8'(exp_cnt)});
      end
      drive_bit(w[32-k], boundary(k, gran) && (k < 32 || more));
    end
  endtask

  task automatic send_burst(input int n, input bit fresh);
    if (fresh) exp_cnt = 0;
    drive_bit(1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      seed++;
      send_word(gen(seed), i < n - 1);
    end
    sfr = pol;
  endtask

  task automatic gap();
    repeat (400) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0 && aerr == 1'b0, "R1 reset outputs", {30'd0, valid, aerr}, 32'h0);
    check(wcnt == 8'd0, "R8 reset count", 32'(wcnt), 32'h0);
    check(bact == 1'b0, "R9 reset burst flag", 32'(bact), 32'h0);

    // R2 R3 R11: junk before strobe ignored, 10 MHz, every word strobed
    gran = 2'b11; pol = 1'b0; half = 12; sfr = pol;
    for (int i = 0; i < 5; i++) drive_bit(1'b1, 1'b0);
    send_burst(3, 1'b1);
    gap();
    check(err_seen == 0, "R3 no alignment error", 32'(err_seen), 32'h0);

    // R4 R7 R11: single strobe per burst, active-low strobe, 5 MHz
    gran = 2'b00; pol = 1'b1; half = 25; sfr = pol;
    @(negedge clk);
    send_burst(4, 1'b1);
    gap();
    check(err_seen == 0, "R4 R7 no alignment error", 32'(err_seen), 32'h0);

    // R5: interior strobes every 8 and every 16 bits
    gran = 2'b01; pol = 1'b0; half = 12; sfr = pol;
    @(negedge clk);
    send_burst(3, 1'b1);
    gap();
    gran = 2'b10;
    send_burst(2, 1'b1);
    gap();
    check(err_seen == 0, "R5 interior strobes accepted", 32'(err_seen), 32'h0);

    // R6: misplaced strobe after 11 bits in 8-bit mode
    gran = 2'b01; exp_cnt = 0;
    drive_bit(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b1);
    send_word(32'hC0DE_F00D, 1'b0);
    sfr = pol;
    gap();
    check(err_seen == 1, "R6 alignment error pulse", 32'(err_seen), 32'h1);

    // R9: partial word then quiet bit clock
    gran = 2'b11;
    drive_bit(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) drive_bit(1'b1, 1'b0);
    check(bact == 1'b1, "R9 burst active during burst", 32'(bact), 32'h1);
    gap();
    check(bact == 1'b0, "R9 burst ended by timeout", 32'(bact), 32'h0);
    send_burst(1, 1'b1);
    gap();

    // R10: continuous bit clock between bursts in 32-bit mode
    send_burst(1, 1'b1);
    for (int i = 0; i < 40; i++) drive_bit(1'b1, 1'b0);
    send_burst(2, 1'b0);
    gap();

    check(q.size() == 0, "R1 all words delivered", 32'(q.size()), 32'h0);
    check(err_seen == 1, "R6 R10 no further errors", 32'(err_seen), 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule